// File: doc/BRIEF.md
# Processor Bus Cycle Controller

This block sits between a processor core and a 32-bit external bus and runs one single-transfer read or write cycle at a time. The core presents a word address, four byte-lane enables, three cycle-type flags (write versus read, data versus code, memory versus I/O) and, for writes, the data word. The controller accepts the request and places it on the bus. It asserts an address strobe for exactly one clock and then waits in a data phase until the external ready input is seen.

Every cycle lasts at least two clocks: a strobe clock followed by one or more data clocks. The data clock repeats as a wait state for as long as ready stays low. On writes the controller drives the data bus and one even-parity bit per byte lane. On reads it leaves the data bus undriven and captures the word on the edge where ready is sampled high. It also checks the incoming lane parity of the enabled bytes and reports the result in the clock that follows completion.

The core learns that a cycle has finished from a one-clock completion pulse. A new request may be handed over in the same clock in which the running cycle completes, so cycles can follow each other without an idle clock.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is held and until the first request, the strobe is low, the completion and parity-error outputs are low, the parity outputs are zero, the data bus is not driven by the block and `req_ready` is high.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The strobe is high during the next clock (the first clock of the cycle), and the address, byte-enable and type outputs equal the request fields during that clock.
- R3: The strobe is high only in the first clock of a cycle. Address, byte enables and type outputs keep their values for the whole cycle and hold them while the block is idle.
- R4: A cycle takes at least two clocks. The ready input is ignored during the strobe clock, and the earliest completion is the edge that ends the second clock.
- R5: In every data clock where ready is low, the data clock repeats as a wait state. The cycle completes on the first edge that ends a data clock with ready high.
- R6: `req_ready` is high exactly when the block is idle, or when it is in a data clock with ready high. A request accepted at completion starts its strobe clock immediately after.
- R7: During every clock of a write cycle, the data bus carries the request's write word. During read cycles and idle clocks the block does not drive the data bus.
- R8: `bus_par_o[i]` equals the XOR of bits 8i+7..8i of the write word while a write cycle runs, so that each byte together with its bit has an even number of ones. It is zero in all other clocks.
- R9: `done_o` is high for exactly one clock, the clock after each completion edge. On reads, `rdata_o` then holds the data bus value sampled at the completion edge, and keeps it until the next read completes. Writes leave `rdata_o` unchanged.
- R10: `par_err_o` is high in the clock after a read completes exactly when some lane i with `bus_be_o[i]`=1 has `bus_par_i[i]` differing from the XOR of its byte. Lanes with a zero enable are ignored, and the output is always low after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | ADDR_W | Word address |
| req_be | input | DATA_W/8 | Byte-lane enables |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_dc | input | 1 | 1 = data, 0 = code |
| req_mio | input | 1 | 1 = memory, 0 = I/O |
| req_wdata | input | DATA_W | Write word |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Last captured read word |
| par_err_o | output | 1 | Read parity mismatch on an enabled lane |
| bus_strobe_o | output | 1 | Address strobe, high in first clock of a cycle |
| bus_addr_o | output | ADDR_W | Bus word address |
| bus_be_o | output | DATA_W/8 | Bus byte enables |
| bus_wr_o | output | 1 | Bus write/read type |
| bus_dc_o | output | 1 | Bus data/code type |
| bus_mio_o | output | 1 | Bus memory/I/O type |
| bus_data | inout | DATA_W | Bidirectional data bus |
| bus_par_o | output | DATA_W/8 | Write lane parity |
| bus_par_i | input | DATA_W/8 | Read lane parity from the responder |
| bus_rdy | input | 1 | Ready from the responder |

## Verification
The bench builds the block with its defaults: a 32-bit data bus, giving four byte lanes, and a 30-bit word address. With these values every lane of both parity paths is checked, including lanes whose enable is zero while their incoming parity is corrupted. The ready input is toggled pseudo-randomly, so that zero, one and long runs of wait states occur. It is also raised during strobe clocks to show it is ignored there. Requests arrive on most clocks, which makes back-to-back cycles frequent, including handovers at the completion edge.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic wr;
        logic dc;
        logic mio;
    } cyc_kind_t;

endpackage

// File: rtl/bcc_lane_parity.sv
module bcc_lane_parity #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [LANES-1:0]  par_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par_o[g] = ^word_i[8*g +: 8];
    end

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  cyc_kind_t         req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              rd_par_bad,
    output phase_e            phase_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  be_o,
    output cyc_kind_t         kind_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              perr_o
);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        cyc_kind_t         kind;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              perr;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    finish;
    logic    accept;

    always_comb begin
        finish    = (st_q.ph == PH_DATA) && bus_rdy;
        req_ready = (st_q.ph == PH_IDLE) || finish;
        accept    = req_valid && req_ready;

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.perr = 1'b0;

        unique case (st_q.ph)
            PH_ADDR: st_d.ph = PH_DATA;
            PH_DATA: if (finish) st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase

        if (finish) begin
            st_d.done = 1'b1;
            if (!st_q.kind.wr) begin
                st_d.rdata = rd_word;
                st_d.perr  = rd_par_bad;
            end
        end

        if (accept) begin
            st_d.ph    = PH_ADDR;
            st_d.addr  = req_addr;
            st_d.be    = req_be;
            st_d.kind  = req_kind;
            st_d.wdata = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign addr_o  = st_q.addr;
    assign be_o    = st_q.be;
    assign kind_o  = st_q.kind;
    assign wdata_o = st_q.wdata;
    assign rdata_o = st_q.rdata;
    assign done_o  = st_q.done;
    assign perr_o  = st_q.perr;

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic              req_wr,
    input  logic              req_dc,
    input  logic              req_mio,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              par_err_o,
    output logic              bus_strobe_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [LANES-1:0]  bus_be_o,
    output logic              bus_wr_o,
    output logic              bus_dc_o,
    output logic              bus_mio_o,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic [LANES-1:0]  bus_par_o,
    input  logic [LANES-1:0]  bus_par_i,
    input  logic              bus_rdy
);

    phase_e            phase;
    cyc_kind_t         req_kind;
    cyc_kind_t         cur_kind;
    logic [DATA_W-1:0] cur_wdata;
    logic [LANES-1:0]  wr_par;
    logic [LANES-1:0]  rd_par;
    logic              rd_par_bad;
    logic              drive_bus;

    assign req_kind = '{wr: req_wr, dc: req_dc, mio: req_mio};

    bcc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_kind   (req_kind),
        .req_wdata  (req_wdata),
        .bus_rdy    (bus_rdy),
        .rd_word    (bus_data),
        .rd_par_bad (rd_par_bad),
        .phase_o    (phase),
        .addr_o     (bus_addr_o),
        .be_o       (bus_be_o),
        .kind_o     (cur_kind),
        .wdata_o    (cur_wdata),
        .rdata_o    (rdata_o),
        .done_o     (done_o),
        .perr_o     (par_err_o)
    );

    bcc_lane_parity #(.DATA_W(DATA_W)) u_wr_par (
        .word_i (cur_wdata),
        .par_o  (wr_par)
    );

    bcc_lane_parity #(.DATA_W(DATA_W)) u_rd_par (
        .word_i (bus_data),
        .par_o  (rd_par)
    );

    assign rd_par_bad   = |((rd_par ^ bus_par_i) & bus_be_o);
    assign drive_bus    = (phase != PH_IDLE) && cur_kind.wr;
    assign bus_data     = drive_bus ? cur_wdata : 'z;
    assign bus_par_o    = drive_bus ? wr_par : '0;
    assign bus_strobe_o = (phase == PH_ADDR);
    assign bus_wr_o     = cur_kind.wr;
    assign bus_dc_o     = cur_kind.dc;
    assign bus_mio_o    = cur_kind.mio;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bus_strobe_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [LANES-1:0]  bus_be_o,
    input logic              bus_wr_o,
    input logic [LANES-1:0]  bus_par_o,
    input logic              done_o,
    input logic              par_err_o
);

    assert_strobe_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_strobe_o);

    assert_strobe_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe_o) |-> $past(req_valid && req_ready));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe_o |=> !bus_strobe_o);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe_o |=> ($stable(bus_addr_o) && $stable(bus_be_o) && $stable(bus_wr_o)));

    assert_min_two_clocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe_o |=> !done_o);

    assert_no_take_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe_o |-> !req_ready);

    assert_par_only_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_par_o != '0) |-> bus_wr_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_perr_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> done_o);

endmodule

bind bus_cycle_ctrl bcc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bcc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .bus_strobe_o (bus_strobe_o),
    .bus_addr_o   (bus_addr_o),
    .bus_be_o     (bus_be_o),
    .bus_wr_o     (bus_wr_o),
    .bus_par_o    (bus_par_o),
    .done_o       (done_o),
    .par_err_o    (par_err_o)
);

// File: tb/tb_bus_cycle_ctrl.sv
module tb_bus_cycle_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 30;
    localparam int DW = 32;
    localparam int NL = DW / 8;
    localparam int RUN_CYCLES = 4000;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [NL-1:0] req_be = '0;
    logic          req_wr = 1'b0;
    logic          req_dc = 1'b0;
    logic          req_mio = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          done_o;
    logic [DW-1:0] rdata_o;
    logic          par_err_o;
    logic          bus_strobe_o;
    logic [AW-1:0] bus_addr_o;
    logic [NL-1:0] bus_be_o;
    logic          bus_wr_o;
    logic          bus_dc_o;
    logic          bus_mio_o;
    wire  [DW-1:0] bus_data;
    logic [NL-1:0] bus_par_o;
    logic [NL-1:0] bus_par_i = '0;
    logic          bus_rdy = 1'b0;

    logic [DW-1:0] tb_drv = '0;
    logic          tb_oe;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    int            m_ph = 0;
    logic          m_wr = 0, m_dc = 0, m_mio = 0;
    logic [AW-1:0] m_addr = '0;
    logic [NL-1:0] m_be = '0;
    logic [DW-1:0] m_wd = '0, m_rd = '0;
    logic          m_done = 0, m_perr = 0;
    logic          m_acc;
    logic          m_fin;
    int            m_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be(req_be),
        .req_wr(req_wr), .req_dc(req_dc), .req_mio(req_mio),
        .req_wdata(req_wdata),
        .done_o(done_o), .rdata_o(rdata_o), .par_err_o(par_err_o),
        .bus_strobe_o(bus_strobe_o), .bus_addr_o(bus_addr_o), .bus_be_o(bus_be_o),
        .bus_wr_o(bus_wr_o), .bus_dc_o(bus_dc_o), .bus_mio_o(bus_mio_o),
        .bus_data(bus_data), .bus_par_o(bus_par_o), .bus_par_i(bus_par_i),
        .bus_rdy(bus_rdy)
    );

    assign tb_oe = (m_ph != 0) && !m_wr;
    assign bus_data = tb_oe ? tb_drv : 'z;

    function automatic logic [NL-1:0] lane_par(input logic [DW-1:0] w);
        logic [NL-1:0] p;
        for (int i = 0; i < NL; i++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(w[8*i+b]);
            p[i] = (ones % 2) == 1;
        end
        return p;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_wr = 0; m_dc = 0; m_mio = 0;
            m_addr = '0; m_be = '0; m_wd = '0; m_rd = '0;
            m_done = 0; m_perr = 0; m_len = 0;
        end else begin
            m_fin  = (m_ph == 2) && bus_rdy;
            m_acc  = req_valid && ((m_ph == 0) || m_fin);
            m_done = 0;
            m_perr = 0;
            if (m_fin) begin
                m_done = 1;
                if (!m_wr) begin
                    m_rd   = tb_drv;
                    m_perr = |((lane_par(tb_drv) ^ bus_par_i) & m_be);
                end
            end
            if (m_ph == 1) m_ph = 2;
            else if (m_fin) m_ph = 0;
            if (m_ph != 0) m_len++;
            if (m_acc) begin
                m_ph = 1; m_len = 1;
                m_addr = req_addr; m_be = req_be;
                m_wr = req_wr; m_dc = req_dc; m_mio = req_mio;
                m_wd = req_wdata;
            end
        end
    end

    task automatic compare_outputs();
        check("R2 R3 strobe", 64'(bus_strobe_o), 64'(m_ph == 1));
        check("R2 R3 addr", 64'(bus_addr_o), 64'(m_addr));
        check("R2 R3 byte enables", 64'(bus_be_o), 64'(m_be));
        check("R2 R3 type", 64'({bus_wr_o, bus_dc_o, bus_mio_o}), 64'({m_wr, m_dc, m_mio}));
        check("R4 R5 R9 done", 64'(done_o), 64'(m_done));
        check("R9 rdata", 64'(rdata_o), 64'(m_rd));
        check("R10 parity error", 64'(par_err_o), 64'(m_perr));
        check("R8 write parity", 64'(bus_par_o),
              64'((m_ph != 0 && m_wr) ? lane_par(m_wd) : '0));
        if (m_ph != 0 && m_wr) check("R7 write data", 64'(bus_data), 64'(m_wd));
        if (tb_oe) check("R7 released on read", 64'(bus_data), 64'(tb_drv));
        if (m_ph == 1) check("R4 first clock not final", 64'(m_len), 64'd1);
    endtask

    initial begin
        // reset state, R1
        repeat (3) @(negedge clk);
        check("R1 strobe", 64'(bus_strobe_o), 64'd0);
        check("R1 done", 64'(done_o), 64'd0);
        check("R1 parity error", 64'(par_err_o), 64'd0);
        check("R1 parity out", 64'(bus_par_o), 64'd0);
        check("R1 ready", 64'(req_ready), 64'd1);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            @(negedge clk);
            compare_outputs();
            // new stimulus
            req_valid = ($urandom % 4) != 0;
            req_addr  = AW'($urandom);
            req_be    = NL'($urandom);
            req_wr    = ($urandom % 2) == 0;
            req_dc    = ($urandom % 2) == 0;
            req_mio   = ($urandom % 2) == 0;
            req_wdata = $urandom;
            if ((cyc / 400) % 2 == 1) bus_rdy = ($urandom % 6) == 0;
            else                      bus_rdy = ($urandom % 2) == 0;
            tb_drv    = $urandom;
            bus_par_i = lane_par(tb_drv) ^ ((($urandom % 4) == 0) ? NL'(1 << ($urandom % NL)) : '0);
            #1;
            // R6 acceptance window
            check("R6 req_ready", 64'(req_ready), 64'((m_ph == 0) || (m_ph == 2 && bus_rdy)));
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule